// File: doc/BRIEF.md
# Announced Block Count Tracker

This block follows the transfer length that a card host announces ahead of a multi-block data transfer. A set-block-count command (index 23) that arrives while the card is in the transfer state loads its 32-bit argument as the number of blocks still to move. The count survives only if the next command is a multi-block read (index 18) or a multi-block write (index 25). Any other command cancels it.

While the card sits in a data state, the data path pulses a block-complete strobe at the end of every block, for reads and for writes. Each strobe lowers a nonzero count by one. The strobe that brings the count to zero raises a one-cycle stop request, which tells the card controller to return to the transfer state without waiting for a stop command. A count of zero means the transfer is open-ended and ends only by other means, such as the stop-transmission command (index 12), which also wipes any residual count. The block also answers every set-block-count command with a one-cycle accept flag or a one-cycle illegal flag.

Top module: `blkcnt_tracker`

## Requirements
- R1: A command with index 23 while the card state code is 4 (transfer) loads the argument into the count. One cycle later the accept flag pulses and the count output shows the argument.
- R2: A command with index 23 in any state other than 4 pulses the illegal flag one cycle later and leaves the count at zero.
- R3: Any command whose index is not 18, 23 or 25 clears the count.
- R4: A command with index 12 clears the count, even when a block-complete strobe arrives in the same cycle.
- R5: Commands with index 18 or 25 leave the count unchanged.
- R6: A block-complete strobe while the state code is 5 (sending) or 6 (receiving) and the count is nonzero lowers the count by one.
- R7: When a strobe lowers the count from one to zero, the stop output is high for exactly one cycle, in the same cycle the count output shows zero.
- R8: With a count of zero (open-ended transfer), a strobe leaves the count at zero and raises no stop.
- R9: A block-complete strobe in any state other than 5 or 6 has no effect on the count.
- R10: Synchronous reset clears the count, the stop output and both command flags.
- R11: When a command and a block-complete strobe arrive in the same cycle, only the command takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| card_state | input | 3 | Card state code (4 transfer, 5 sending, 6 receiving) |
| blk_done | input | 1 | Block-complete pulse from the data path |
| stop_req | output | 1 | One-cycle request to return to transfer state |
| setcnt_ok | output | 1 | Set-block-count accepted (R1 response) |
| setcnt_illegal | output | 1 | Set-block-count rejected as illegal |
| blocks_left | output | 32 | Remaining announced block count |

## Verification
The bench builds the block with its default widths: a 32-bit count and a 6-bit command index. With those widths it can load the all-ones argument and watch it step down without wrapping. It can also load a count of one and see the stop request on the very first block. A zero argument reaches the open-ended case. The state code is three bits wide, so every non-transfer state and every non-data state can be driven to exercise the rejection and ignore paths.

// File: rtl/blkcnt_pkg.sv
package blkcnt_pkg;

    typedef enum logic [2:0] {
        CS_IDLE  = 3'd0,
        CS_READY = 3'd1,
        CS_IDENT = 3'd2,
        CS_STBY  = 3'd3,
        CS_XFER  = 3'd4,
        CS_SEND  = 3'd5,
        CS_RECV  = 3'd6,
        CS_OTHER = 3'd7
    } card_state_e;

    localparam int IDX_W = 6;

    localparam logic [IDX_W-1:0] IDX_STOP   = 6'd12;
    localparam logic [IDX_W-1:0] IDX_MREAD  = 6'd18;
    localparam logic [IDX_W-1:0] IDX_SETCNT = 6'd23;
    localparam logic [IDX_W-1:0] IDX_MWRITE = 6'd25;

    typedef struct packed {
        logic load;
        logic reject;
        logic clear;
        logic any_cmd;
    } cmd_act_t;

    function automatic logic is_data_state(input logic [2:0] st);
        return (st == CS_SEND) || (st == CS_RECV);
    endfunction

    function automatic logic is_multi_xfer(input logic [IDX_W-1:0] idx);
        return (idx == IDX_MREAD) || (idx == IDX_MWRITE);
    endfunction

endpackage

// File: rtl/blkcnt_cmd_decode.sv
module blkcnt_cmd_decode
    import blkcnt_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [IDX_W-1:0] cmd_index,
    input  logic [2:0]       card_state,
    output cmd_act_t         act
);
    logic is_setcnt;
    logic accept;
    logic keep;

    always_comb begin
        is_setcnt   = cmd_valid && (cmd_index == IDX_SETCNT);
        accept      = is_setcnt && (card_state == CS_XFER);
        keep        = cmd_valid && is_multi_xfer(cmd_index);
        act.load    = accept;
        act.reject  = is_setcnt && !accept;
        act.clear   = cmd_valid && !accept && !keep;
        act.any_cmd = cmd_valid;
    end
endmodule

// File: rtl/blkcnt_counter.sv
module blkcnt_counter
    import blkcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_act_t         act,
    input  logic [CNT_W-1:0] load_val,
    input  logic             blk_done,
    input  logic [2:0]       card_state,
    output logic [CNT_W-1:0] count,
    output logic             stop
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic step;

    always_comb begin
        step = !act.any_cmd && blk_done && is_data_state(card_state)
               && (count != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            stop  <= 1'b0;
        end else begin
            stop <= 1'b0;
            if (act.load) begin
                count <= load_val;
            end else if (act.clear) begin
                count <= '0;
            end else if (step) begin
                count <= count - ONE;
                stop  <= (count == ONE);
            end
        end
    end
endmodule

// File: rtl/blkcnt_tracker.sv
module blkcnt_tracker
    import blkcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [IDX_W-1:0] cmd_index,
    input  logic [CNT_W-1:0] cmd_arg,
    input  logic [2:0]       card_state,
    input  logic             blk_done,
    output logic             stop_req,
    output logic             setcnt_ok,
    output logic             setcnt_illegal,
    output logic [CNT_W-1:0] blocks_left
);
    cmd_act_t act;

    blkcnt_cmd_decode u_dec (
        .cmd_valid  (cmd_valid),
        .cmd_index  (cmd_index),
        .card_state (card_state),
        .act        (act)
    );

    blkcnt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .load_val   (cmd_arg),
        .blk_done   (blk_done),
        .card_state (card_state),
        .count      (blocks_left),
        .stop       (stop_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            setcnt_ok      <= 1'b0;
            setcnt_illegal <= 1'b0;
        end else begin
            setcnt_ok      <= act.load;
            setcnt_illegal <= act.reject;
        end
    end
endmodule

// File: rtl/blkcnt_tracker_checker.sv
module blkcnt_tracker_checker
    import blkcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [IDX_W-1:0] cmd_index,
    input logic [CNT_W-1:0] cmd_arg,
    input logic [2:0]       card_state,
    input logic             blk_done,
    input logic             stop_req,
    input logic             setcnt_ok,
    input logic             setcnt_illegal,
    input logic [CNT_W-1:0] blocks_left
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    p_accept_loads_r1: assert property (@(posedge clk) disable iff (rst)
        setcnt_ok |-> (blocks_left == $past(cmd_arg)));

    p_reject_zero_r2: assert property (@(posedge clk) disable iff (rst)
        setcnt_illegal |-> (blocks_left == '0 && !setcnt_ok));

    p_multi_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && is_multi_xfer(cmd_index)) |=> $stable(blocks_left));

    p_step_down_r6: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid && blk_done && is_data_state(card_state) && blocks_left != '0)
        |=> (blocks_left == $past(blocks_left) - ONE));

    p_stop_single_r7: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !stop_req);

    p_stop_at_zero_r7: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> (blocks_left == '0 && $past(blocks_left) == ONE));

    p_idle_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid && blk_done && !is_data_state(card_state)) |=> $stable(blocks_left));

    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> (blocks_left == '0 && !stop_req && !setcnt_ok && !setcnt_illegal));
endmodule

bind blkcnt_tracker blkcnt_tracker_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/blkcnt_tracker_bench.sv
module blkcnt_tracker_bench;
    localparam int CNT_W = 32;

    typedef struct packed {
        logic        valid;
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [2:0]  st;
        logic        blk;
        logic        e_stop;
        logic        e_ok;
        logic        e_ill;
        logic [31:0] e_cnt;
        logic [7:0]  req;
    } vec_t;

    function automatic vec_t mk(input logic v, input logic [5:0] i, input logic [31:0] a,
                                input logic [2:0] s, input logic b, input logic es,
                                input logic eo, input logic ei, input logic [31:0] ec,
                                input logic [7:0] r);
        return '{v, i, a, s, b, es, eo, ei, ec, r};
    endfunction

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        mk(1, 23, 3, 4, 0, 0, 1, 0, 3, 1),          // R1 load 3
        mk(1, 25, 0, 4, 0, 0, 0, 0, 3, 5),          // R5 write keeps
        mk(0, 0, 0, 6, 1, 0, 0, 0, 2, 6),           // R6
        mk(0, 0, 0, 6, 1, 0, 0, 0, 1, 6),           // R6
        mk(0, 0, 0, 6, 1, 1, 0, 0, 0, 7),           // R7 stop
        mk(0, 0, 0, 6, 1, 0, 0, 0, 0, 8),           // R8 zero count
        mk(1, 23, 5, 4, 0, 0, 1, 0, 5, 1),          // R1
        mk(1, 13, 0, 4, 0, 0, 0, 0, 0, 3),          // R3 other cmd clears
        mk(1, 23, 2, 4, 0, 0, 1, 0, 2, 1),          // R1
        mk(1, 18, 0, 4, 0, 0, 0, 0, 2, 5),          // R5 read keeps
        mk(0, 0, 0, 4, 1, 0, 0, 0, 2, 9),           // R9 not data state
        mk(0, 0, 0, 5, 1, 0, 0, 0, 1, 6),           // R6 read block
        mk(1, 12, 0, 5, 1, 0, 0, 0, 0, 4),          // R4 R11 stop cmd with block
        mk(1, 23, 9, 3, 0, 0, 0, 1, 0, 2),          // R2 standby
        mk(1, 23, 7, 4, 0, 0, 1, 0, 7, 1),          // R1
        mk(1, 23, 1, 6, 0, 0, 0, 1, 0, 2),          // R2 clears too
        mk(1, 23, 1, 4, 0, 0, 1, 0, 1, 1),          // R1
        mk(1, 18, 0, 4, 0, 0, 0, 0, 1, 5),          // R5
        mk(0, 0, 0, 5, 0, 0, 0, 0, 1, 6),           // R6 no strobe
        mk(0, 0, 0, 5, 1, 1, 0, 0, 0, 7),           // R7 stop on first block
        mk(0, 0, 0, 5, 0, 0, 0, 0, 0, 7),           // R7 one cycle only
        mk(1, 23, 0, 4, 0, 0, 1, 0, 0, 8),          // R8 open-ended
        mk(1, 18, 0, 4, 0, 0, 0, 0, 0, 5),          // R5
        mk(0, 0, 0, 5, 1, 0, 0, 0, 0, 8),           // R8 no stop
        mk(1, 23, 32'hFFFF_FFFF, 4, 0, 0, 1, 0, 32'hFFFF_FFFF, 1), // R1 max
        mk(1, 25, 0, 4, 1, 0, 0, 0, 32'hFFFF_FFFF, 11),            // R11 cmd wins
        mk(0, 0, 0, 6, 1, 0, 0, 0, 32'hFFFF_FFFE, 6)               // R6
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             cmd_valid;
    logic [5:0]       cmd_index;
    logic [CNT_W-1:0] cmd_arg;
    logic [2:0]       card_state;
    logic             blk_done;
    logic             stop_req;
    logic             setcnt_ok;
    logic             setcnt_illegal;
    logic [CNT_W-1:0] blocks_left;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    blkcnt_tracker #(.CNT_W(CNT_W)) u_blkcnt_tracker (
        .clk            (clk),
        .rst            (rst),
        .cmd_valid      (cmd_valid),
        .cmd_index      (cmd_index),
        .cmd_arg        (cmd_arg),
        .card_state     (card_state),
        .blk_done       (blk_done),
        .stop_req       (stop_req),
        .setcnt_ok      (setcnt_ok),
        .setcnt_illegal (setcnt_illegal),
        .blocks_left    (blocks_left)
    );

    task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s stop/ok/ill/count actual=%b/%b/%b/%h expected=%b/%b/%b/%h",
                     req, act[34], act[33], act[32], act[31:0],
                     exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic drive(input logic v, input logic [5:0] i, input logic [31:0] a,
                         input logic [2:0] s, input logic b);
        @(negedge clk);
        cmd_valid = v; cmd_index = i; cmd_arg = a; card_state = s; blk_done = b;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [34:0] outs();
        return {stop_req, setcnt_ok, setcnt_illegal, blocks_left};
    endfunction

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_index = '0; cmd_arg = '0;
        card_state = 3'd4; blk_done = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset state", outs(), 35'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k].valid, VEC[k].idx, VEC[k].arg, VEC[k].st, VEC[k].blk);
            check($sformatf("R%0d vector %0d", VEC[k].req, k), outs(),
                  {VEC[k].e_stop, VEC[k].e_ok, VEC[k].e_ill, VEC[k].e_cnt});
        end

        // R10: reset while a count is pending
        drive(1, 6'd23, 32'd40, 3'd4, 0);
        check("R1 load before reset", outs(), {3'b010, 32'd40});
        @(negedge clk);
        rst = 1'b1; cmd_valid = 1'b0; blk_done = 1'b0;
        @(posedge clk);
        #1;
        check("R10 reset clears count", outs(), 35'd0);
        @(negedge clk);
        rst = 1'b0;

        // R3: another non-transfer command (index 55) cancels the count
        drive(1, 6'd23, 32'd6, 3'd4, 0);
        drive(1, 6'd55, 32'd0, 3'd4, 0);
        check("R3 index 55 clears", outs(), 35'd0);

        // R9: receiving-state strobes only count in data states; state 7 ignored
        drive(1, 6'd23, 32'd2, 3'd4, 0);
        drive(1, 6'd25, 32'd0, 3'd4, 0);
        drive(0, 6'd0, 32'd0, 3'd7, 1);
        check("R9 state 7 strobe ignored", outs(), {3'b000, 32'd2});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule